// File: doc/BRIEF.md
# Periodic Sensor Measurement Scheduler

This block decides when each of up to four sensing points is sampled. A free-running time base divides the input clock into period ticks of (period unit × 2^TICK_SHIFT) clocks; with the default shift of 8 each tick lasts (period unit × 256) clocks. Every scheduling decision falls on a tick. Within a round the enabled points are visited in ascending index order. Each point takes as many samples as its filter mode asks for. Three interval counts set the spacing: one between samples of the same point, one between the last sample of a point and the next enabled point, and one between the end of a round and the start of the next.

A point in immediate mode takes a single sample. Its filter mode is ignored, and whatever follows that sample happens on the very next tick. The block drives a one-clock sample strobe with the index of the point to convert, plus a round-done pulse on the last strobe of a round. The converter and the temperature arithmetic are outside this block. The configuration is captured when a round starts, so a mid-round change only affects the following round.

Top module: `meas_sched`

## Requirements
- R1: A tick comes every max(period_unit,1) × 2^TICK_SHIFT clocks, so a period unit of zero behaves as one. All strobe spacings are whole multiples of this tick length.
- R2: Two consecutive samples of the same point are (filt_ival + 1) ticks apart. An interval of zero therefore means the next tick.
- R3: A point that is not in immediate mode takes N samples per round. Its 3-bit field filt_mode[3i+2:3i] gives N: code 0→1, 1→2, 2→4, 3→6, 4→10, and 5, 6 or 7→18.
- R4: Enabled points are sampled in ascending index order. The first sample of the next enabled point comes (sens_ival + 1) ticks after the last sample of the previous point.
- R5: A point whose bit in sens_en is 0 gets no strobes and uses no sensor interval. Every strobe index is enabled in the configuration captured for that round.
- R6: round_done is high together with the last strobe of a round, and only then. The first strobe of the next round comes (grp_ival + 1) ticks later.
- R7: A point whose imm_en bit is set takes exactly one sample per round. The next action after that sample (next point or next round) happens one tick later.
- R8: While sens_en is all zero at a round start, no strobe is issued. Once the map becomes nonzero, the first enabled point is sampled on the next tick.
- R9: The enable map, intervals, filter modes and immediate bits are captured when a round starts. Changes made during a round take effect from the next round.
- R10: After reset both outputs are low. A strobe lasts one clock and comes in the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sens_en | input | 4 | Enable map of the sensing points, bit i = point i |
| period_unit | input | 10 | Tick length in units of 2^TICK_SHIFT clocks |
| filt_ival | input | 10 | Ticks between samples of the same point |
| sens_ival | input | 10 | Ticks between consecutive points |
| grp_ival | input | 10 | Ticks between rounds |
| filt_mode | input | 12 | Three bits per point selecting the sample count |
| imm_en | input | 4 | Immediate-mode bit per point |
| smp_strobe | output | 1 | One-clock sample request |
| smp_idx | output | 2 | Index of the point to sample |
| round_done | output | 1 | High with the last strobe of a round |

## Verification
The assertions check on every cycle that:
- ticks and strobes are single-clock pulses;
- a strobe always follows a tick;
- round_done never appears without a strobe;
- each strobed index is enabled in the captured configuration;
- no strobe is issued while idle with an empty map.

The exact spacing in ticks, the sample counts per filter code, the ascending order, the skipping of disabled points, the immediate-mode shortcut and the capture of the configuration at a round boundary can only be shown by the bench's scenarios. The bench sweeps filter codes, every nonzero enable map with and without immediate points, and several period units. It compares each strobe's index, round-done flag and spacing with an arithmetic model of the rounds.

// File: rtl/meas_sched_pkg.sv
package meas_sched_pkg;
    localparam int NSENS = 4;
    localparam int IW    = $clog2(NSENS);
    localparam int VW    = 10;
    localparam int MW    = 3;
    localparam int LW    = 5;

    typedef struct packed {
        logic [NSENS-1:0]    en;
        logic [NSENS-1:0]    imm;
        logic [NSENS*MW-1:0] mode;
        logic [VW-1:0]       filt;
        logic [VW-1:0]       sens;
        logic [VW-1:0]       grp;
    } cfg_t;

    // samples per round for a filter code
    function automatic logic [LW-1:0] mode_count(input logic [MW-1:0] m);
        case (m)
            3'd0:    return LW'(1);
            3'd1:    return LW'(2);
            3'd2:    return LW'(4);
            3'd3:    return LW'(6);
            3'd4:    return LW'(10);
            default: return LW'(18);
        endcase
    endfunction

    function automatic logic [LW-1:0] sens_count(input cfg_t c, input logic [IW-1:0] i);
        if (c.imm[i]) return LW'(1);
        return mode_count(c.mode[i*MW +: MW]);
    endfunction
endpackage

// File: rtl/meas_tick.sv
module meas_tick #(
    parameter int VW         = 10,
    parameter int TICK_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] unit,
    output logic          tick
);
    localparam int CW = VW + TICK_SHIFT;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;
    logic [VW-1:0] unit_eff;
    logic [CW-1:0] limit;

    assign unit_eff = (unit == '0) ? VW'(1) : unit;
    assign limit    = {unit_eff, {TICK_SHIFT{1'b0}}} - CW'(1);

    always_comb begin
        tick_d = (cnt_q >= limit);
        cnt_d  = tick_d ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    // the tick is a single-clock pulse (TICK_SHIFT >= 1)
    assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/meas_pick.sv
module meas_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  en,
    input  logic [IW-1:0] from,
    input  logic          incl,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest enabled index above 'from' (or equal when incl)
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en[i] && ((i > int'(from)) || (incl && (i == int'(from))))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/meas_sched.sv
module meas_sched
    import meas_sched_pkg::*;
#(
    parameter int TICK_SHIFT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSENS-1:0]    sens_en,
    input  logic [VW-1:0]       period_unit,
    input  logic [VW-1:0]       filt_ival,
    input  logic [VW-1:0]       sens_ival,
    input  logic [VW-1:0]       grp_ival,
    input  logic [NSENS*MW-1:0] filt_mode,
    input  logic [NSENS-1:0]    imm_en,
    output logic                smp_strobe,
    output logic [IW-1:0]       smp_idx,
    output logic                round_done
);
    typedef struct packed {
        logic          in_round;
        logic [IW-1:0] idx;
        logic [LW-1:0] left;
        logic [VW-1:0] dly;
        cfg_t          cfg;
        logic          strobe;
        logic [IW-1:0] sidx;
        logic          done;
    } st_t;

    st_t           d, q;
    logic          tick;
    cfg_t          live, cfg_use;
    logic          first_found, next_found;
    logic [IW-1:0] first_idx, next_idx, cur_idx;
    logic [LW-1:0] cur_left;

    meas_tick #(.VW(VW), .TICK_SHIFT(TICK_SHIFT)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .unit  (period_unit),
        .tick  (tick)
    );

    assign live.en   = sens_en;
    assign live.imm  = imm_en;
    assign live.mode = filt_mode;
    assign live.filt = filt_ival;
    assign live.sens = sens_ival;
    assign live.grp  = grp_ival;

    // a round runs on its captured copy; a new round reads the inputs
    assign cfg_use = q.in_round ? q.cfg : live;

    meas_pick #(.N(NSENS), .IW(IW)) u_first (
        .en    (live.en),
        .from  ('0),
        .incl  (1'b1),
        .found (first_found),
        .idx   (first_idx)
    );

    assign cur_idx  = q.in_round ? q.idx : first_idx;
    assign cur_left = q.in_round ? q.left : sens_count(cfg_use, cur_idx);

    meas_pick #(.N(NSENS), .IW(IW)) u_next (
        .en    (cfg_use.en),
        .from  (cur_idx),
        .incl  (1'b0),
        .found (next_found),
        .idx   (next_idx)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        d.done   = 1'b0;
        if (tick) begin
            if (q.dly != '0) begin
                d.dly = q.dly - VW'(1);
            end else if (q.in_round || first_found) begin
                d.cfg    = cfg_use;
                d.strobe = 1'b1;
                d.sidx   = cur_idx;
                if (cur_left > LW'(1)) begin
                    d.in_round = 1'b1;
                    d.idx      = cur_idx;
                    d.left     = cur_left - LW'(1);
                    d.dly      = cfg_use.filt;
                end else if (next_found) begin
                    d.in_round = 1'b1;
                    d.idx      = next_idx;
                    d.left     = sens_count(cfg_use, next_idx);
                    d.dly      = cfg_use.imm[cur_idx] ? '0 : cfg_use.sens;
                end else begin
                    d.in_round = 1'b0;
                    d.done     = 1'b1;
                    d.dly      = cfg_use.imm[cur_idx] ? '0 : cfg_use.grp;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign smp_strobe = q.strobe;
    assign smp_idx    = q.sidx;
    assign round_done = q.done;

    assert_strobe_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |-> $past(tick));
    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |=> !q.strobe);
    assert_done_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.strobe);
    assert_strobe_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.strobe |-> q.cfg.en[q.sidx]);
    assert_idle_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.in_round && q.dly == '0 && !first_found) |=> !q.strobe);
endmodule

// File: tb/test_meas_sched.sv
module test_meas_sched;
    localparam int CLK_PERIOD = 10;
    localparam int TSH        = 4;
    localparam int MAXR       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sens_en = '0;
    logic [9:0]  period_unit = 10'd1;
    logic [9:0]  filt_ival = '0, sens_ival = '0, grp_ival = '0;
    logic [11:0] filt_mode = '0;
    logic [3:0]  imm_en = '0;
    logic        smp_strobe, round_done;
    logic [1:0]  smp_idx;

    int checks = 0, failures = 0;
    int cyc = 0, nrec = 0;
    int rec_t [MAXR];
    int rec_i [MAXR];
    int rec_d [MAXR];
    int e_idx [MAXR];
    int e_gap [MAXR];
    int e_kind[MAXR];
    int e_done[MAXR];

    always #(CLK_PERIOD/2) clk = ~clk;

    meas_sched #(.TICK_SHIFT(TSH)) i_meas_sched (
        .clk(clk), .rst_n(rst_n), .sens_en(sens_en), .period_unit(period_unit),
        .filt_ival(filt_ival), .sens_ival(sens_ival), .grp_ival(grp_ival),
        .filt_mode(filt_mode), .imm_en(imm_en), .smp_strobe(smp_strobe),
        .smp_idx(smp_idx), .round_done(round_done)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (smp_strobe && nrec < MAXR) begin
            rec_t[nrec] = cyc;
            rec_i[nrec] = int'(smp_idx);
            rec_d[nrec] = int'(round_done);
            nrec = nrec + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int mcount(input int code, input bit imm);
        if (imm) return 1;
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 10;
            default: return 18;
        endcase
    endfunction

    function automatic string kind_tag(input int k);
        case (k)
            1: return "R2";
            2: return "R4 R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic build(input logic [3:0] m, input logic [11:0] md, input logic [3:0] im,
                         input int f, input int sv, input int g, input int want);
        int n = 0, pend = 0, pkind = 1, last = 0;
        for (int i = 0; i < 4; i++) if (m[i]) last = i;
        while (n < want) begin
            for (int i = 0; i < 4; i++) begin
                if (m[i]) begin
                    int cnt = mcount(int'(md[3*i +: 3]), im[i]);
                    for (int j = 0; j < cnt; j++) begin
                        if (n < want) begin
                            e_idx[n]  = i;
                            e_gap[n]  = pend;
                            e_kind[n] = pkind;
                            e_done[n] = (i == last && j == cnt - 1) ? 1 : 0;
                            n++;
                        end
                        pend = f + 1; pkind = 1;
                    end
                    if (im[i])          begin pend = 1;      pkind = 4; end
                    else if (i != last) begin pend = sv + 1; pkind = 2; end
                    else                begin pend = g + 1;  pkind = 3; end
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        nrec = 0;
        rst_n = 1'b1;
    endtask

    task automatic run_seq(input string ctx, input int pu, input logic [3:0] m,
                           input logic [11:0] md, input logic [3:0] im,
                           input int f, input int sv, input int g, input int want);
        int tt = ((pu == 0) ? 1 : pu) << TSH;
        @(negedge clk);
        period_unit = 10'(pu); sens_en = m; filt_mode = md; imm_en = im;
        filt_ival = 10'(f); sens_ival = 10'(sv); grp_ival = 10'(g);
        build(m, md, im, f, sv, g, want);
        do_reset();
        for (int c = 0; c < 40000 && nrec < want; c++) @(posedge clk);
        chk(nrec >= want, "R2", {ctx, " strobe count"}, nrec, want);
        for (int k = 0; k < want && k < nrec; k++) begin
            chk(rec_i[k] == e_idx[k], "R3 R4 R5", {ctx, " index"}, rec_i[k], e_idx[k]);
            chk(rec_d[k] == e_done[k], "R6", {ctx, " round_done"}, rec_d[k], e_done[k]);
            if (k > 0)
                chk(rec_t[k] - rec_t[k-1] == e_gap[k] * tt, kind_tag(e_kind[k]),
                    {ctx, " spacing"}, rec_t[k] - rec_t[k-1], e_gap[k] * tt);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        sens_en = 4'b0001;
        do_reset();
        @(negedge clk);
        chk(smp_strobe == 1'b0, "R10", "strobe after reset", int'(smp_strobe), 0);
        chk(round_done == 1'b0, "R10", "done after reset", int'(round_done), 0);

        // R3: every filter code on one point
        for (int code = 0; code < 8; code++)
            run_seq("R3 code", 1, 4'b0001, 12'(code), 4'b0000, 1, 0, 2,
                    2 * mcount(code, 1'b0) + 1);

        // R4 R5 R7: every nonzero map, with and without immediate points
        for (int mm = 1; mm < 16; mm++) begin
            run_seq("R5 map", 1, 4'(mm), {3'd1, 3'd2, 3'd1, 3'd0}, 4'b0000, 0, 1, 2, 20);
            run_seq("R7 map", 1, 4'(mm), {3'd1, 3'd2, 3'd1, 3'd0}, 4'b1010, 0, 1, 2, 20);
        end

        // R1: period unit, zero acting as one
        for (int p = 0; p < 4; p++)
            run_seq("R1 unit", (p == 3) ? 5 : p, 4'b1001, 12'd0, 4'b0000, 0, 2, 1, 8);

        // R8: empty map stays idle, then starts on the next tick
        begin
            int tset;
            @(negedge clk);
            period_unit = 10'd1; sens_en = 4'b0000; filt_mode = '0; imm_en = '0;
            filt_ival = '0; sens_ival = '0; grp_ival = '0;
            do_reset();
            repeat (300) @(negedge clk);
            chk(nrec == 0, "R8", "strobes with empty map", nrec, 0);
            sens_en = 4'b0100;
            tset = cyc;
            repeat ((1 << TSH) + 4) @(negedge clk);
            chk(nrec >= 1, "R8", "start after map set", nrec, 1);
            chk(rec_i[0] == 2, "R8", "first index", rec_i[0], 2);
            chk(rec_t[0] - tset <= (1 << TSH) + 2, "R8", "start latency",
                rec_t[0] - tset, (1 << TSH) + 2);
        end

        // R9: change during a round applies from the next round
        begin
            int tt = 1 << TSH;
            @(negedge clk);
            period_unit = 10'd1; sens_en = 4'b0011; filt_mode = '0; imm_en = '0;
            filt_ival = '0; sens_ival = 10'd1; grp_ival = '0;
            do_reset();
            for (int c = 0; c < 2000 && nrec < 1; c++) @(negedge clk);
            sens_en = 4'b0110; sens_ival = 10'd5;
            for (int c = 0; c < 4000 && nrec < 4; c++) @(negedge clk);
            chk(nrec >= 4, "R9", "strobe count", nrec, 4);
            chk(rec_i[0] == 0, "R9", "idx0", rec_i[0], 0);
            chk(rec_i[1] == 1 && rec_d[1] == 1, "R9", "old round ends on point 1", rec_i[1], 1);
            chk(rec_t[1] - rec_t[0] == 2 * tt, "R9", "old sensor interval",
                rec_t[1] - rec_t[0], 2 * tt);
            chk(rec_i[2] == 1 && rec_t[2] - rec_t[1] == tt, "R9", "new round start",
                rec_t[2] - rec_t[1], tt);
            chk(rec_i[3] == 2 && rec_d[3] == 1, "R9", "new map point 2", rec_i[3], 2);
            chk(rec_t[3] - rec_t[2] == 6 * tt, "R9", "new sensor interval",
                rec_t[3] - rec_t[2], 6 * tt);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule